// File: doc/BRIEF.md
# Packet-Interface Transmit Word Scheduler

This block produces the 16-bit word stream of a packet-over-parallel-link transmitter, one word per clock, with a flag that marks control words. In each cycle it chooses one of five word kinds: a payload control word, an idle control word, a training control word, a payload data word or a training data word. The choice depends on three things. The first is the receive status channel's sync state, which can be overridden by a no-status option. The second is whether a burst descriptor is waiting. The third is a timer that inserts training sequences periodically.

Each burst descriptor gives a logical port, a length in 16-bit words, and flags for start of packet, end of packet, an errored packet and a single valid byte in the final word. The logical port is translated to an 8-bit physical address through a 256-entry table, which is loaded through a write port. Payload words are pulled from the source by a take strobe, in the same cycle they are used. Every control word carries a 4-bit parity code that covers the data words sent since the previous control word.

Top module: `txWordSched`

## Requirements
- R1: While `rstN` is low, `txWord` is 0x000F and `txCtl` is 1. The parity accumulator, the timers and the pending end status all clear.
- R2: Word formats. A payload control word is {1, eops[1:0], sop, addr[7:0], dip[3:0]}. An idle control word is {0, eops[1:0], 0, 8'h00, dip[3:0]}. The training control word is 0x0FFF and the training data word is 0xF000. `txCtl` is 1 for every control word and 0 for every data word.
- R3: When `linkOk` and `noStatus` are both low, every burst boundary starts a training sequence. No descriptor is accepted there. A sequence is one idle word followed by `trainReps` repetitions of ten training control words and then ten training data words.
- R4: When `noStatus` is high, payload flows as if `linkOk` were high.
- R5: In a cycle at a burst boundary with no accepted descriptor and no training to start, an idle control word is sent.
- R6: Two payload control words with sop=1 are at least 8 cycles apart. While a start-of-packet descriptor waits for this gap, idle words are sent. A descriptor without start of packet is accepted with no wait.
- R7: When `trainPeriod` is P (non-zero), a training sequence starts at the first burst boundary on which at least P non-training cycles have passed. The count runs from reset or from the end of the last sequence. A burst in progress is never cut. P = 0 turns periodic training off.
- R8: The first control word after a burst's final data word carries that burst's end status. The codes are 01 when the error flag is set (regardless of the end-of-packet flag), 11 for end of packet with one valid byte, 10 for end of packet with two valid bytes, and 00 when the burst does not end the packet. All other control words carry 00.
- R9: The address field of a payload control word is the table entry at `descPort`, as last written through `mapWrEn`/`mapWrAddr`/`mapWrData`.
- R10: If `descOneByte` is set, bits [7:0] of the burst's final data word are sent as 0x00.
- R11: The parity code is computed as follows. X is the XOR of every payload data word sent since the previous control word, taken as sent, XOR'd with the control word whose code field is 1111. The code is X[15:12]^X[11:8]^X[7:4]^X[3:0].
- R12: `descReady` is high only with `descValid`, and only in the cycle the payload control word for that descriptor is chosen. That word is on `txWord` one cycle later. `dataTake` is high in each cycle a data word is chosen. `dataWord` is sampled in that cycle and is on `txWord` one cycle later. Exactly `descLen` (at least 1) takes occur per descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkOk | input | 1 | Status channel is in sync |
| noStatus | input | 1 | Ignore status channel, send payload anyway |
| trainPeriod | input | PERIOD_W | Non-training cycles between training sequences, 0 = off |
| trainReps | input | REPS_W | Pattern repetitions per training sequence |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Descriptor accepted this cycle |
| descSop | input | 1 | Burst starts a packet |
| descEop | input | 1 | Burst ends a packet |
| descErr | input | 1 | Packet is errored, end with abort |
| descOneByte | input | 1 | Final word has only its high byte valid |
| descLen | input | LEN_W | Burst length in 16-bit words |
| descPort | input | LID_W | Logical port |
| dataTake | output | 1 | Data word consumed this cycle |
| dataWord | input | 16 | Payload data word |
| mapWrEn | input | 1 | Port table write enable |
| mapWrAddr | input | LID_W | Port table write index |
| mapWrData | input | 8 | Port table physical address |
| txWord | output | 16 | Transmit word |
| txCtl | output | 1 | Transmit word is a control word |

## Verification
The word-kind choice is made combinationally in cycle n, and `descReady` and `dataTake` are asserted in that same cycle. The chosen word is registered and appears on `txWord` in cycle n+1. The bench therefore samples the outputs at falling edges. The k-th word captured after reset release belongs to the k-th decision. Expected streams are built by counting decisions: one for the control word, `descLen` for the data, an eight-decision window from one start of packet to the next, P+1 idle words before each periodic sequence, and 1+20·reps words per training sequence. Parity codes and table addresses are computed arithmetically from the R11 and R9 formulas.

// File: rtl/txSchedPkg.sv
package txSchedPkg;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_PAYCTL,
    SEL_DATA,
    SEL_TCTL,
    SEL_TDATA
  } wordSelT;

  typedef struct packed {
    wordSelT    sel;
    logic       sop;
    logic [1:0] eops;
    logic       zeroLow;
  } pathCmdT;

  localparam logic [15:0] TRAIN_CTL_WORD  = 16'h0FFF;
  localparam logic [15:0] TRAIN_DATA_WORD = 16'hF000;
  localparam logic [15:0] IDLE_RESET_WORD = 16'h000F;

  localparam logic [1:0] EOPS_NONE  = 2'b00;
  localparam logic [1:0] EOPS_ABORT = 2'b01;
  localparam logic [1:0] EOPS_TWO   = 2'b10;
  localparam logic [1:0] EOPS_ONE   = 2'b11;

  function automatic logic [3:0] dipFold(input logic [15:0] x);
    return x[15:12] ^ x[11:8] ^ x[7:4] ^ x[3:0];
  endfunction

endpackage

// File: rtl/txSchedCtrl.sv
module txSchedCtrl
  import txSchedPkg::*;
#(
  parameter int LEN_W       = 6,
  parameter int PERIOD_W    = 16,
  parameter int REPS_W      = 4,
  parameter int MIN_SOP_GAP = 8,
  parameter int TRAIN_RUN   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                linkOk,
  input  logic                noStatus,
  input  logic [PERIOD_W-1:0] trainPeriod,
  input  logic [REPS_W-1:0]   trainReps,
  input  logic                descValid,
  input  logic                descSop,
  input  logic                descEop,
  input  logic                descErr,
  input  logic                descOneByte,
  input  logic [LEN_W-1:0]    descLen,
  output logic                descReady,
  output logic                dataTake,
  output pathCmdT             cmd
);

  localparam int GAP_W = (MIN_SOP_GAP > 2) ? $clog2(MIN_SOP_GAP) : 1;
  localparam int PH_W  = $clog2(2 * TRAIN_RUN);
  localparam logic [PH_W-1:0]  PH_RUN  = PH_W'(TRAIN_RUN);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(2 * TRAIN_RUN - 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_SOP_GAP - 1);

  typedef enum logic [1:0] {ST_GAP, ST_BURST, ST_TRAIN} stateT;

  stateT              state;
  logic [LEN_W-1:0]   remain;
  logic               bOneByte, bEop, bErr;
  logic [1:0]         pendEops;
  logic [GAP_W-1:0]   sopWait;
  logic [PERIOD_W-1:0] timer;
  logic [PH_W-1:0]    phase;
  logic [REPS_W-1:0]  rep;

  logic linkUp, trainDue, sopOk, startTrain, takeDesc, lastWord;
  logic [1:0] endEops;

  assign linkUp   = linkOk | noStatus;
  assign trainDue = (trainPeriod != '0) && (timer >= trainPeriod);
  assign sopOk    = (sopWait == '0);
  assign lastWord = (remain == LEN_W'(1));
  assign endEops  = bErr ? EOPS_ABORT :
                    bEop ? (bOneByte ? EOPS_ONE : EOPS_TWO) : EOPS_NONE;

  always_comb begin
    cmd        = '{sel: SEL_IDLE, sop: 1'b0, eops: EOPS_NONE, zeroLow: 1'b0};
    descReady  = 1'b0;
    dataTake   = 1'b0;
    startTrain = 1'b0;
    takeDesc   = 1'b0;
    case (state)
      ST_GAP: begin
        cmd.eops = pendEops;
        if (!linkUp || trainDue) begin
          startTrain = 1'b1;
        end else if (descValid && (!descSop || sopOk)) begin
          takeDesc  = 1'b1;
          descReady = 1'b1;
          cmd.sel   = SEL_PAYCTL;
          cmd.sop   = descSop;
        end
      end
      ST_BURST: begin
        cmd.sel     = SEL_DATA;
        dataTake    = 1'b1;
        cmd.zeroLow = lastWord & bOneByte;
      end
      default: begin
        cmd.sel = (phase < PH_RUN) ? SEL_TCTL : SEL_TDATA;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_GAP;
      remain   <= '0;
      bOneByte <= 1'b0;
      bEop     <= 1'b0;
      bErr     <= 1'b0;
      pendEops <= EOPS_NONE;
      sopWait  <= '0;
      timer    <= '0;
      phase    <= '0;
      rep      <= '0;
    end else begin
      if (!sopOk) sopWait <= sopWait - 1'b1;
      if (state != ST_TRAIN && timer < trainPeriod) timer <= timer + 1'b1;
      case (state)
        ST_GAP: begin
          pendEops <= EOPS_NONE;
          if (startTrain) begin
            if (trainReps == '0) begin
              timer <= '0;
            end else begin
              state <= ST_TRAIN;
              phase <= '0;
              rep   <= '0;
            end
          end else if (takeDesc) begin
            state    <= ST_BURST;
            remain   <= descLen;
            bOneByte <= descOneByte;
            bEop     <= descEop;
            bErr     <= descErr;
            if (descSop) sopWait <= GAP_LOAD;
          end
        end
        ST_BURST: begin
          remain <= remain - 1'b1;
          if (lastWord) begin
            state    <= ST_GAP;
            pendEops <= endEops;
          end
        end
        default: begin
          if (phase == PH_LAST) begin
            phase <= '0;
            rep   <= rep + 1'b1;
            if (rep == trainReps - REPS_W'(1)) begin
              state <= ST_GAP;
              timer <= '0;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/txSchedPath.sv
module txSchedPath
  import txSchedPkg::*;
#(
  parameter int LID_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCmdT          cmd,
  input  logic [LID_W-1:0] descPort,
  input  logic [15:0]      dataWord,
  input  logic             mapWrEn,
  input  logic [LID_W-1:0] mapWrAddr,
  input  logic [7:0]       mapWrData,
  output logic [15:0]      txWord,
  output logic             txCtl
);

  localparam int MAP_DEPTH = 2 ** LID_W;

  logic [7:0]  mapMem [MAP_DEPTH];
  logic [7:0]  physPort;
  logic [15:0] parity, dataOut, ctlBase, nextWord;
  logic        nextCtl;
  logic [3:0]  dipVal;

  always_ff @(posedge clk) begin
    if (mapWrEn) mapMem[mapWrAddr] <= mapWrData;
  end

  assign physPort = mapMem[descPort];
  assign dataOut  = cmd.zeroLow ? {dataWord[15:8], 8'h00} : dataWord;
  assign ctlBase  = (cmd.sel == SEL_PAYCTL) ?
                    {1'b1, cmd.eops, cmd.sop, physPort, 4'hF} :
                    {1'b0, cmd.eops, 1'b0, 8'h00, 4'hF};
  assign dipVal   = dipFold(parity ^ ctlBase);

  always_comb begin
    case (cmd.sel)
      SEL_DATA:  begin nextWord = dataOut;         nextCtl = 1'b0; end
      SEL_TCTL:  begin nextWord = TRAIN_CTL_WORD;  nextCtl = 1'b1; end
      SEL_TDATA: begin nextWord = TRAIN_DATA_WORD; nextCtl = 1'b0; end
      default:   begin nextWord = {ctlBase[15:4], dipVal}; nextCtl = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord <= IDLE_RESET_WORD;
      txCtl  <= 1'b1;
      parity <= '0;
    end else begin
      txWord <= nextWord;
      txCtl  <= nextCtl;
      parity <= (cmd.sel == SEL_DATA) ? (parity ^ dataOut) : '0;
    end
  end

endmodule

// File: rtl/txWordSched.sv
module txWordSched
  import txSchedPkg::*;
#(
  parameter int LID_W       = 8,
  parameter int LEN_W       = 6,
  parameter int PERIOD_W    = 16,
  parameter int REPS_W      = 4,
  parameter int MIN_SOP_GAP = 8,
  parameter int TRAIN_RUN   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                linkOk,
  input  logic                noStatus,
  input  logic [PERIOD_W-1:0] trainPeriod,
  input  logic [REPS_W-1:0]   trainReps,
  input  logic                descValid,
  output logic                descReady,
  input  logic                descSop,
  input  logic                descEop,
  input  logic                descErr,
  input  logic                descOneByte,
  input  logic [LEN_W-1:0]    descLen,
  input  logic [LID_W-1:0]    descPort,
  output logic                dataTake,
  input  logic [15:0]         dataWord,
  input  logic                mapWrEn,
  input  logic [LID_W-1:0]    mapWrAddr,
  input  logic [7:0]          mapWrData,
  output logic [15:0]         txWord,
  output logic                txCtl
);

  pathCmdT cmd;

  txSchedCtrl #(
    .LEN_W(LEN_W), .PERIOD_W(PERIOD_W), .REPS_W(REPS_W),
    .MIN_SOP_GAP(MIN_SOP_GAP), .TRAIN_RUN(TRAIN_RUN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .linkOk(linkOk), .noStatus(noStatus),
    .trainPeriod(trainPeriod), .trainReps(trainReps),
    .descValid(descValid), .descSop(descSop), .descEop(descEop),
    .descErr(descErr), .descOneByte(descOneByte), .descLen(descLen),
    .descReady(descReady), .dataTake(dataTake), .cmd(cmd)
  );

  txSchedPath #(.LID_W(LID_W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .descPort(descPort),
    .dataWord(dataWord), .mapWrEn(mapWrEn), .mapWrAddr(mapWrAddr),
    .mapWrData(mapWrData), .txWord(txWord), .txCtl(txCtl)
  );

endmodule

// File: rtl/txSchedChecker.sv
module txSchedChecker #(
  parameter int MIN_SOP_GAP = 8
) (
  input logic clk,
  input logic rstN,
  input logic linkOk,
  input logic noStatus,
  input logic descValid,
  input logic descReady,
  input logic dataTake,
  input logic txCtl,
  input logic txType,
  input logic txSop
);

  localparam int CNT_W = $clog2(MIN_SOP_GAP + 1);
  localparam logic [CNT_W-1:0] GAP_MAX = CNT_W'(MIN_SOP_GAP);

  logic [CNT_W-1:0] sinceSop;
  logic sopOut;

  assign sopOut = txCtl & txType & txSop;

  always_ff @(posedge clk) begin
    if (!rstN)              sinceSop <= GAP_MAX;
    else if (sopOut)        sinceSop <= CNT_W'(1);
    else if (sinceSop < GAP_MAX) sinceSop <= sinceSop + 1'b1;
  end

  AST_NO_PAYLOAD_UNSYNCED: assert property (@(posedge clk) disable iff (!rstN)
    (!linkOk && !noStatus) |-> !descReady); // R3

  AST_SOP_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    sopOut |-> (sinceSop >= GAP_MAX)); // R6

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    descReady |-> descValid); // R12

  AST_CTL_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    descReady |=> (txCtl && txType)); // R12

  AST_DATA_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    dataTake |=> !txCtl); // R2

endmodule

bind txWordSched txSchedChecker #(.MIN_SOP_GAP(MIN_SOP_GAP)) u_chk (
  .clk(clk), .rstN(rstN), .linkOk(linkOk), .noStatus(noStatus),
  .descValid(descValid), .descReady(descReady), .dataTake(dataTake),
  .txCtl(txCtl), .txType(txWord[15]), .txSop(txWord[12])
);

// File: tb/test_txWordSched.sv
module test_txWordSched;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, linkOk, noStatus;
  logic [15:0] trainPeriod;
  logic [3:0]  trainReps;
  logic        descValid, descReady, descSop, descEop, descErr, descOneByte;
  logic [5:0]  descLen;
  logic [7:0]  descPort;
  logic        dataTake;
  logic [15:0] dataWord;
  logic        mapWrEn;
  logic [7:0]  mapWrAddr, mapWrData;
  logic [15:0] txWord;
  logic        txCtl;

  txWordSched i_txWordSched (.*);

  int checks = 0, errors = 0;
  logic [15:0] capW [0:127];
  logic        capC [0:127];
  logic [15:0] dataMem [0:63];
  int dIdx, takeCount;
  bit sawReady;
  int   dLen [0:3];
  bit   dSop [0:3], dEop [0:3], dErr [0:3], dOne [0:3];
  int   dPort [0:3];

  assign dataWord = dataMem[dIdx];

  always @(posedge clk) begin
    if (!rstN) dIdx <= 0;
    else if (dataTake) dIdx <= dIdx + 1;
  end

  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (dataTake) takeCount++;
      if (descReady && descValid) sawReady = 1;
    end
  end

  function automatic logic [7:0] mapOf(int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  function automatic logic [3:0] fold16(logic [15:0] x);
    return x[15:12] ^ x[11:8] ^ x[7:4] ^ x[3:0];
  endfunction

  function automatic logic [15:0] ctlW(bit pay, logic [1:0] eops, bit sop,
                                       logic [7:0] addr, logic [15:0] acc);
    logic [15:0] b;
    b = {pay, eops, sop, addr, 4'hF};
    return {b[15:4], fold16(acc ^ b)};
  endfunction

  task automatic expW(int i, logic ctl, logic [15:0] w, string req);
    checks++;
    if (capC[i] !== ctl || capW[i] !== w) begin
      errors++;
      $display("FAIL %s word %0d actual %b/%h expected %b/%h", req, i, capC[i], capW[i], ctl, w);
    end
  endtask

  task automatic expTrue(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic feed(int n, int limit);
    for (int k = 0; k < n; k++) begin
      bit took;
      took        = 0;
      descSop     = dSop[k];
      descEop     = dEop[k];
      descErr     = dErr[k];
      descOneByte = dOne[k];
      descLen     = 6'(dLen[k]);
      descPort    = 8'(dPort[k]);
      descValid   = 1'b1;
      for (int t = 0; t < limit && !took; t++) begin
        #1;
        took = descReady;
        @(negedge clk);
      end
    end
    descValid = 1'b0;
  endtask

  task automatic runScenario(int nCap, int nDesc);
    descValid = 1'b0;
    rstN      = 1'b0;
    repeat (3) @(negedge clk);
    takeCount = 0;
    sawReady  = 0;
    expTrue(txWord == 16'h000F && txCtl == 1'b1, "R1 reset word", int'(txWord), 16'h000F);
    rstN = 1'b1;
    fork
      begin
        for (int i = 0; i < nCap; i++) begin
          @(negedge clk);
          capW[i] = txWord;
          capC[i] = txCtl;
        end
      end
      feed(nDesc, nCap - 2);
    join
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] acc;
    rstN = 1'b0; linkOk = 1'b0; noStatus = 1'b0; trainPeriod = '0; trainReps = 4'd1;
    descValid = 1'b0; descSop = 0; descEop = 0; descErr = 0; descOneByte = 0;
    descLen = '0; descPort = '0; mapWrEn = 1'b0; mapWrAddr = '0; mapWrData = '0;
    for (int i = 0; i < 64; i++) dataMem[i] = 16'(i * 16'h0101 + 16'h0F31);
    @(negedge clk);
    mapWrEn = 1'b1;
    for (int i = 0; i < 256; i++) begin
      mapWrAddr = 8'(i);
      mapWrData = mapOf(i);
      @(negedge clk);
    end
    mapWrEn = 1'b0;
    expTrue(txWord == 16'h000F && txCtl, "R1 during reset", int'(txWord), 16'h000F);

    // R3: out of sync, only training sequences, descriptor ignored
    linkOk = 0; noStatus = 0; trainReps = 4'd2; trainPeriod = 0;
    dLen[0] = 1; dSop[0] = 1; dEop[0] = 1; dErr[0] = 0; dOne[0] = 0; dPort[0] = 4;
    runScenario(90, 1);
    for (int i = 0; i < 82; i++) begin
      int j;
      j = i % 41;
      if (j == 0)                  expW(i, 1'b1, 16'h000F, "R3 leading idle");
      else if (((j - 1) % 20) < 10) expW(i, 1'b1, 16'h0FFF, "R3 R2 training control");
      else                         expW(i, 1'b0, 16'hF000, "R3 R2 training data");
    end
    expTrue(!sawReady && takeCount == 0, "R3 no payload accepted", takeCount, 0);

    // R2 R9 R10 R11 R12 R5 R8: single burst, one valid byte at end
    linkOk = 1; noStatus = 0; trainReps = 1; trainPeriod = 0;
    dataMem[0] = 16'h1234; dataMem[1] = 16'hABCD; dataMem[2] = 16'h5E7F;
    dLen[0] = 3; dSop[0] = 1; dEop[0] = 1; dErr[0] = 0; dOne[0] = 1; dPort[0] = 5;
    runScenario(60, 1);
    expW(0, 1'b1, ctlW(1, 2'b00, 1, mapOf(5), 16'h0), "R9 R11 R2 payload control");
    expW(1, 1'b0, 16'h1234, "R12 data word");
    expW(2, 1'b0, 16'hABCD, "R12 data word");
    expW(3, 1'b0, 16'h5E00, "R10 zero-filled low byte");
    expW(4, 1'b1, ctlW(0, 2'b11, 0, 8'h00, 16'h1234 ^ 16'hABCD ^ 16'h5E00), "R8 R11 idle with one-byte end");
    for (int i = 5; i < 60; i++) expW(i, 1'b1, 16'h000F, "R5 R7 idle with training off");
    expTrue(sawReady && takeCount == 3, "R12 take count", takeCount, 3);

    // R4 R6 R8: no-status option, two SOP bursts back to back
    linkOk = 0; noStatus = 1;
    dataMem[0] = 16'hC0DE; dataMem[1] = 16'h0BAD;
    dLen[0] = 1; dSop[0] = 1; dEop[0] = 1; dErr[0] = 0; dOne[0] = 0; dPort[0] = 7;
    dLen[1] = 1; dSop[1] = 1; dEop[1] = 1; dErr[1] = 0; dOne[1] = 0; dPort[1] = 9;
    runScenario(14, 2);
    expW(0, 1'b1, ctlW(1, 2'b00, 1, mapOf(7), 16'h0), "R4 payload despite no sync");
    expW(1, 1'b0, 16'hC0DE, "R4 data");
    expW(2, 1'b1, ctlW(0, 2'b10, 0, 8'h00, 16'hC0DE), "R8 two-byte end on idle");
    for (int i = 3; i < 8; i++) expW(i, 1'b1, 16'h000F, "R6 idle fill for SOP gap");
    expW(8, 1'b1, ctlW(1, 2'b00, 1, mapOf(9), 16'h0), "R6 second SOP after 8 cycles");
    expW(9, 1'b0, 16'h0BAD, "R6 data");
    expW(10, 1'b1, ctlW(0, 2'b10, 0, 8'h00, 16'h0BAD), "R8 end");

    // R6 R8 R11: continuation without gap, errored ending aborts
    linkOk = 1; noStatus = 0;
    dataMem[0] = 16'h1111; dataMem[1] = 16'h2222; dataMem[2] = 16'h3333;
    dLen[0] = 2; dSop[0] = 1; dEop[0] = 0; dErr[0] = 0; dOne[0] = 0; dPort[0] = 3;
    dLen[1] = 1; dSop[1] = 0; dEop[1] = 0; dErr[1] = 1; dOne[1] = 0; dPort[1] = 3;
    runScenario(10, 2);
    expW(0, 1'b1, ctlW(1, 2'b00, 1, mapOf(3), 16'h0), "R6 first burst");
    expW(3, 1'b1, ctlW(1, 2'b00, 0, mapOf(3), 16'h1111 ^ 16'h2222), "R6 R8 R11 continuation no wait");
    expW(4, 1'b0, 16'h3333, "R10 no fill without flag");
    expW(5, 1'b1, ctlW(0, 2'b01, 0, 8'h00, 16'h3333), "R8 abort on error");
    expW(6, 1'b1, 16'h000F, "R5 idle");

    // R8 R9: end status carried on the next payload control word
    acc = '0;
    for (int i = 0; i < 8; i++) begin
      dataMem[i] = 16'(16'h9000 + i * 16'h0313);
      acc ^= dataMem[i];
    end
    dataMem[8] = 16'h7788;
    dLen[0] = 8; dSop[0] = 1; dEop[0] = 1; dErr[0] = 0; dOne[0] = 0; dPort[0] = 200;
    dLen[1] = 1; dSop[1] = 1; dEop[1] = 1; dErr[1] = 0; dOne[1] = 1; dPort[1] = 0;
    runScenario(14, 2);
    for (int i = 1; i < 9; i++) expW(i, 1'b0, dataMem[i - 1], "R12 long burst data");
    expW(9, 1'b1, ctlW(1, 2'b10, 1, mapOf(0), acc), "R8 R9 R11 end status on payload control");
    expW(10, 1'b0, 16'h7700, "R10 fill");
    expW(11, 1'b1, ctlW(0, 2'b11, 0, 8'h00, 16'h7700), "R8 one-byte end");

    // R7: periodic training with no traffic
    trainPeriod = 16'd5; trainReps = 4'd1;
    runScenario(40, 0);
    for (int i = 0; i < 35; i++) begin
      if (i < 6 || (i >= 26 && i < 32)) expW(i, 1'b1, 16'h000F, "R7 idle before sequence");
      else if (i < 16 || i >= 32)       expW(i, 1'b1, 16'h0FFF, "R7 training control");
      else                              expW(i, 1'b0, 16'hF000, "R7 training data");
    end

    // R7: training deferred until the burst ends
    trainPeriod = 16'd3;
    acc = '0;
    for (int i = 0; i < 6; i++) begin
      dataMem[i] = 16'(16'h4100 + i * 16'h0107);
      acc ^= dataMem[i];
    end
    dLen[0] = 6; dSop[0] = 1; dEop[0] = 1; dErr[0] = 0; dOne[0] = 0; dPort[0] = 1;
    runScenario(22, 1);
    expW(0, 1'b1, ctlW(1, 2'b00, 1, mapOf(1), 16'h0), "R7 burst starts");
    for (int i = 1; i < 7; i++) expW(i, 1'b0, dataMem[i - 1], "R7 burst not cut");
    expW(7, 1'b1, ctlW(0, 2'b10, 0, 8'h00, acc), "R7 R8 leading idle closes burst");
    for (int i = 8; i < 18; i++) expW(i, 1'b1, 16'h0FFF, "R7 training control");
    expW(18, 1'b0, 16'hF000, "R7 training data");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule